// File: doc/BRIEF.md
# Register-Bus I2C Target

This block lets an external I2C controller read and write a bank of 198 eight-bit configuration registers. It answers only to two fixed address bytes, one for writes and one for reads. Addressing works like a small serial EEPROM: a write transfer first loads an internal register pointer, and every later data byte is stored at the pointer. A read transfer returns bytes starting at whatever the pointer holds. The pointer steps forward after every byte and wraps at the top of the register space, so one transfer can sweep the whole bank.

SCL and SDA arrive already synchronised to the system clock. The block samples them, finds START and STOP conditions and bit edges, and pulls SDA low through an open-drain enable. On the register side it presents an address, write data and a one-cycle write strobe. Read data is taken from a combinational return path. A 2-bit mode strap gates the block: the block takes part on the bus only when the strap selects I2C target operation.

Top module: `i2c_regbus_slave`

## Requirements
- R1: The address byte 0xBE (write) and the address byte 0xBF (read) are acknowledged, i.e. SDA is held low during the ninth clock.
- R2: Any other address byte gets no acknowledge. The rest of that transfer is ignored: no ACK is given and no register is written.
- R3: In a write transfer, the first byte after the address is acknowledged and loads the pointer. Each later byte is acknowledged and written to the register at the pointer, and the pointer then increments.
- R4: A read transfer returns the register at the current pointer, then the following registers. The pointer is 0 after reset and keeps its value between transfers.
- R5: After a byte is read or written at pointer 197, the pointer wraps to 0.
- R6: A pointer byte of 198 or more is acknowledged and sets the pointer to 0.
- R7: When the mode strap is not 2'b01, the block never drives SDA and never writes a register.
- R8: A STOP or a repeated START that arrives part-way through a byte returns the block to address matching. The partial byte is not written and the pointer is unchanged.
- R9: A random read works: write transfer with a pointer byte, then a repeated START, then 0xBF, returns data from the new pointer.
- R10: After the controller NACKs a read byte, the block stops driving SDA for the rest of the transfer.
- R11: The SDA drive is asserted only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_strap_i | input | 2 | Operating mode strap; 2'b01 enables the block |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 8 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o, same cycle |

## Verification
The hardest condition to reach from the ports is a bus condition that cuts a byte short. The block has to drop a half-shifted byte and keep the pointer it had. The stimulus reaches this by sending the first bits of a data byte, then issuing a STOP in one case and a repeated START followed by a read in the other. The read must return the register at the untouched pointer, and the write-strobe count must not change. The pointer wrap is reached by loading pointer 196 and moving three bytes in each direction.

// File: rtl/i2c_regbus_pkg.sv
package i2c_regbus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } state_e;

  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } bus_ev_t;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond
  import i2c_regbus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    ev_o.rise  = scl_i & ~scl_q;
    ev_o.fall  = ~scl_i & scl_q;
    // SDA edge with SCL high on both samples
    ev_o.start = scl_i & scl_q & sda_q & ~sda_i;
    ev_o.stop  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_regbus_ptr.sv
module i2c_regbus_ptr #(
  parameter int NREG = 198,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [7:0]    load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);
  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ptr_q <= '0;
    else if (load_i)          ptr_q <= (32'(load_val_i) < NREG) ? AW'(load_val_i) : '0;
    else if (inc_i)           ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  // R5
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_q == LAST) |=> ptr_q == '0);
  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < NREG);
endmodule

// File: rtl/i2c_regbus_engine.sv
module i2c_regbus_engine
  import i2c_regbus_pkg::*;
#(
  parameter logic [7:0] DEV_WR = 8'hBE,
  parameter logic [7:0] DEV_RD = 8'hBF
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  bus_ev_t    ev_i,
  input  logic       sda_i,
  input  logic [7:0] rdata_i,
  output logic       ptr_load_o,
  output logic       ptr_inc_o,
  output logic [7:0] ptr_val_o,
  output logic       we_o,
  output logic [7:0] wdata_o,
  output logic       sda_oe_o
);
  state_e     state_q;
  logic [2:0] cnt_q;
  logic [7:0] shr_q, tx_q;
  logic       full_q, rd_sel_q, mack_q;
  logic       byte_end, rd_last;

  assign byte_end = en_i & ev_i.fall & full_q;
  assign rd_last  = en_i & ev_i.fall & (state_q == ST_RD) & (cnt_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shr_q    <= '0;
      tx_q     <= '0;
      full_q   <= 1'b0;
      rd_sel_q <= 1'b0;
      mack_q   <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
    end else if (ev_i.start) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      full_q  <= 1'b0;
    end else if (ev_i.stop) begin
      state_q <= ST_IDLE;
      full_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_DEV, ST_PTR, ST_WR: begin
          if (ev_i.rise) begin
            shr_q  <= {shr_q[6:0], sda_i};
            cnt_q  <= cnt_q + 1'b1;
            full_q <= (cnt_q == 3'd7);
          end else if (ev_i.fall && full_q) begin
            full_q <= 1'b0;
            if (state_q == ST_DEV) begin
              if (shr_q == DEV_WR) begin
                state_q  <= ST_DEV_ACK;
                rd_sel_q <= 1'b0;
              end else if (shr_q == DEV_RD) begin
                state_q  <= ST_DEV_ACK;
                rd_sel_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_PTR) begin
              state_q <= ST_PTR_ACK;
            end else begin
              state_q <= ST_WR_ACK;
            end
          end
        end
        ST_DEV_ACK: if (ev_i.fall) begin
          cnt_q <= '0;
          if (rd_sel_q) begin
            state_q <= ST_RD;
            tx_q    <= rdata_i;
          end else begin
            state_q <= ST_PTR;
          end
        end
        ST_PTR_ACK, ST_WR_ACK: if (ev_i.fall) begin
          state_q <= ST_WR;
          cnt_q   <= '0;
        end
        ST_RD: if (ev_i.fall) begin
          if (cnt_q == 3'd7) begin
            state_q <= ST_RD_ACK;
            cnt_q   <= '0;
          end else begin
            tx_q  <= tx_q << 1;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_ACK: begin
          if (ev_i.rise) mack_q <= ~sda_i;
          else if (ev_i.fall) begin
            if (mack_q) begin
              state_q <= ST_RD;
              tx_q    <= rdata_i;
              cnt_q   <= '0;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ptr_load_o = byte_end & (state_q == ST_PTR);
  assign ptr_val_o  = shr_q;
  assign we_o       = byte_end & (state_q == ST_WR);
  assign wdata_o    = shr_q;
  assign ptr_inc_o  = we_o | rd_last;

  assign sda_oe_o = (state_q == ST_DEV_ACK) | (state_q == ST_PTR_ACK) |
                    (state_q == ST_WR_ACK) | ((state_q == ST_RD) & ~tx_q[7]);

  // R11
  oe_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(ev_i.fall));
  // R7
  strap_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o);
  // R8
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.stop |=> (!sda_oe_o && !we_o));
  // R3
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
endmodule

// File: rtl/i2c_regbus_slave.sv
module i2c_regbus_slave
  import i2c_regbus_pkg::*;
#(
  parameter int         NREG     = 198,
  parameter logic [1:0] MODE_SEL = 2'b01,
  parameter logic [7:0] DEV_WR   = 8'hBE,
  parameter logic [7:0] DEV_RD   = 8'hBF,
  localparam int        AW       = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_strap_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [7:0]    reg_wdata_o,
  output logic          reg_we_o,
  input  logic [7:0]    reg_rdata_i
);
  bus_ev_t    ev;
  logic       en;
  logic       ptr_load, ptr_inc;
  logic [7:0] ptr_val;

  assign en = (mode_strap_i == MODE_SEL);

  i2c_bus_cond u_cond (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  i2c_regbus_engine #(.DEV_WR(DEV_WR), .DEV_RD(DEV_RD)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .ev_i      (ev),
    .sda_i     (sda_i),
    .rdata_i   (reg_rdata_i),
    .ptr_load_o(ptr_load),
    .ptr_inc_o (ptr_inc),
    .ptr_val_o (ptr_val),
    .we_o      (reg_we_o),
    .wdata_o   (reg_wdata_o),
    .sda_oe_o  (sda_oe_o)
  );

  i2c_regbus_ptr #(.NREG(NREG)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ptr_load),
    .load_val_i(ptr_val),
    .inc_i     (ptr_inc),
    .ptr_o     (reg_addr_o)
  );

  // R11
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
endmodule

// File: tb/i2c_regbus_slave_test.sv
`timescale 1ns/1ps
module i2c_regbus_slave_test;
  localparam int NREG = 198;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b01;
  logic       scl = 1'b1, sda_m = 1'b1;
  logic       sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       sda_line;
  logic [7:0] mem [NREG];
  logic [7:0] expm [NREG];
  int checks = 0, fails = 0, wcount = 0, bad_oe = 0;

  always #2 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_regbus_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_strap_i(strap),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
    .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) & 8'hFF);
  endfunction

  initial for (int i = 0; i < NREG; i++) begin
    mem[i] = pat(i);
    expm[i] = pat(i);
  end

  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      wcount <= wcount + 1;
    end
    if (rst_n && sda_oe && !$past(sda_oe) && scl) bad_oe <= bad_oe + 1;
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq();
  endtask

  task automatic put_bit(logic b);
    sda_m = b; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1; wq(); scl = 1; wq(); b = sda_line; wq(); scl = 0; wq();
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(logic ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  // write a burst starting at ptr, all acks expected
  task automatic wr_burst(string req, logic [7:0] ptr, logic [7:0] d0, int n);
    logic ack;
    i2c_start();
    send_byte(8'hBE, ack); chk("R1", {7'd0, ack}, 8'd1, "write address ack");
    send_byte(ptr, ack);   chk(req, {7'd0, ack}, 8'd1, "pointer ack");
    for (int i = 0; i < n; i++) begin
      send_byte(8'(d0 + i), ack);
      chk("R3", {7'd0, ack}, 8'd1, "data ack");
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] v;
    chk("R4", {7'd0, sda_oe}, 8'd0, "oe after reset");
    chk("R4", {7'd0, reg_we}, 8'd0, "we after reset");
    chk("R4", reg_addr, 8'd0, "pointer after reset");
    i2c_start();
    send_byte(8'hBF, ack); chk("R1", {7'd0, ack}, 8'd1, "read address ack");
    recv_byte(1'b0, v);    chk("R4", v, expm[0], "first read at reset pointer");
    i2c_stop();
  endtask

  task automatic t_write_read();
    logic ack; logic [7:0] v;
    wr_burst("R3", 8'h20, 8'hA0, 3);
    for (int i = 0; i < 3; i++) expm[8'h20 + i] = 8'(8'hA0 + i);
    for (int i = 0; i < 3; i++) chk("R3", mem[8'h20 + i], expm[8'h20 + i], "burst write");
    i2c_start();
    send_byte(8'hBF, ack); chk("R1", {7'd0, ack}, 8'd1, "read address ack");
    recv_byte(1'b1, v);    chk("R4", v, expm[8'h23], "read continues at pointer");
    recv_byte(1'b0, v);    chk("R4", v, expm[8'h24], "read increments pointer");
    i2c_stop();
  endtask

  task automatic rand_read(string req, logic [7:0] ptr, int n);
    logic ack; logic [7:0] v;
    i2c_start();
    send_byte(8'hBE, ack);
    send_byte(ptr, ack);
    i2c_start();
    send_byte(8'hBF, ack); chk(req, {7'd0, ack}, 8'd1, "read address after restart");
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, v);
      chk(req, v, expm[(int'(ptr) + i) % NREG], "random read data");
    end
    i2c_stop();
  endtask

  task automatic t_wrap();
    wr_burst("R5", 8'd196, 8'h51, 3);
    expm[196] = 8'h51; expm[197] = 8'h52; expm[0] = 8'h53;
    chk("R5", mem[197], 8'h52, "write at top");
    chk("R5", mem[0], 8'h53, "write wrapped to 0");
    rand_read("R5", 8'd196, 3);
  endtask

  task automatic t_clamp();
    wr_burst("R6", 8'hF0, 8'h3C, 1);
    expm[0] = 8'h3C;
    chk("R6", mem[0], 8'h3C, "out-of-range pointer lands at 0");
  endtask

  task automatic t_bad_addr();
    logic ack; int w0 = wcount;
    i2c_start();
    send_byte(8'hA0, ack); chk("R2", {7'd0, ack}, 8'd0, "foreign address nack");
    send_byte(8'h55, ack); chk("R2", {7'd0, ack}, 8'd0, "byte after foreign address");
    i2c_stop();
    i2c_start();
    send_byte(8'hBD, ack); chk("R2", {7'd0, ack}, 8'd0, "near-miss address nack");
    i2c_stop();
    chk("R2", 8'(wcount - w0), 8'd0, "no writes");
  endtask

  task automatic t_strap();
    logic ack; int w0 = wcount;
    for (int s = 0; s < 2; s++) begin
      strap = (s == 0) ? 2'b00 : 2'b10;
      i2c_start();
      send_byte(8'hBE, ack); chk("R7", {7'd0, ack}, 8'd0, "no ack when disabled");
      send_byte(8'h05, ack);
      send_byte(8'h77, ack); chk("R7", {7'd0, ack}, 8'd0, "data ignored when disabled");
      i2c_stop();
    end
    strap = 2'b01;
    wq();
    chk("R7", 8'(wcount - w0), 8'd0, "no writes when disabled");
    chk("R7", mem[5], expm[5], "register untouched");
  endtask

  task automatic t_abort();
    logic ack; logic [7:0] v; int w0 = wcount;
    i2c_start();
    send_byte(8'hBE, ack);
    send_byte(8'h0A, ack);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    i2c_stop();
    chk("R8", 8'(wcount - w0), 8'd0, "stop mid-byte writes nothing");
    chk("R8", mem[10], expm[10], "partial byte dropped");
    i2c_start();
    send_byte(8'hBE, ack);
    send_byte(8'h0B, ack);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    i2c_start();
    send_byte(8'hBF, ack); chk("R8", {7'd0, ack}, 8'd1, "address after restart mid-byte");
    recv_byte(1'b0, v);    chk("R8", v, expm[11], "pointer unchanged by partial byte");
    i2c_stop();
    chk("R8", 8'(wcount - w0), 8'd0, "restart mid-byte writes nothing");
  endtask

  task automatic t_nack_release();
    logic ack, b; logic [7:0] v;
    i2c_start();
    send_byte(8'hBE, ack);
    send_byte(8'h40, ack);
    i2c_start();
    send_byte(8'hBF, ack);
    recv_byte(1'b0, v); chk("R9", v, expm[8'h40], "random read at 0x40");
    chk("R10", {7'd0, sda_oe}, 8'd0, "released after nack");
    get_bit(b);         chk("R10", {7'd0, b}, 8'd1, "line high after nack");
    i2c_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    rand_read("R9", 8'h21, 2);
    t_wrap();
    t_clamp();
    t_bad_addr();
    t_strap();
    t_abort();
    t_nack_release();
    chk("R11", 8'(bad_oe), 8'd0, "drive asserted with SCL high");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule